// File: doc/BRIEF.md
# Adaptive Temporal Contrast Pixel Array

This block is a digital model of a square array of pixels that flags temporal contrast against two adaptive bounds per pixel. Each pixel holds an upper envelope and a lower envelope of its past intensity. When a new frame of samples arrives, each sample is tested against both stored envelopes, giving one bit for "brighter than the upper envelope" and one bit for "darker than the lower envelope". The envelopes then move toward the sample as exponential moving averages whose rate is a power of two chosen by a programmable shift.

Samples enter one pixel per accepted cycle in raster order (row 0 first, column 0 first within a row). Once the last pixel of a frame is accepted, the block stops accepting samples and reads the flag pairs out row by row. Each row is copied in one cycle into a shift register as wide as a row, two bits per stage. The pairs then leave on a two-bit serial output, column 0 first, one pair for each cycle the output shift enable is high. Every pixel is delivered, including pixels with no event. After the last pair of the last row, the block accepts the next frame.

Top module: `atc_array`

## Requirements
- R1: After reset, pixReady is 1 and serValid is 0.
- R2: In the first frame after reset, every delivered flag pair is 0/0, and both envelopes of each pixel are set to that pixel's sample.
- R3: From the second frame on, serHi is 1 exactly when the sample is strictly greater than the upper envelope as it stood before this frame's update, and serLo is 1 exactly when the sample is strictly less than the lower envelope as it stood before this frame's update.
- R4: With k the effective shift and D the decay parameter (default 2), the upper envelope U becomes U + floor((F-U)/2^k) when the sample F is above U, and U + floor((F-U)/2^(k+D)) otherwise. The lower envelope L becomes L + floor((F-L)/2^k) when F is below L, and L + floor((F-L)/2^(k+D)) otherwise.
- R5: The effective shift k equals smoothShift for values 1 to 7. A smoothShift of 0 acts as 1.
- R6: One cycle after the last pixel of a frame is accepted, pixReady is 0. pixReady and serValid are never both 1. Flag pairs leave row by row, rows in increasing order and columns in increasing order, with serHi and serLo showing the pair of the current pixel while serValid is 1. A cycle with shiftEn high advances to the next pixel.
- R7: While serValid is 1 and shiftEn is 0, serValid, serHi and serLo hold their values.
- R8: pixValid while pixReady is 0 has no effect on the envelopes or on any flag later delivered.
- R9: One cycle after the last pair of the last row is shifted out, pixReady is 1 and serValid is 0.
- R10: Between two rows of a frame, serValid is 0 for exactly one cycle, the row load, and pixReady stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smoothShift | input | 3 | Moving-average shift k (0 acts as 1) |
| pixValid | input | 1 | A sample is present on pixData |
| pixData | input | 8 | Pixel intensity sample, unsigned |
| pixReady | output | 1 | Block accepts samples (sample phase) |
| shiftEn | input | 1 | Advance serial output by one pixel |
| serValid | output | 1 | serHi/serLo carry a pixel's flag pair |
| serHi | output | 1 | Sample exceeded the upper envelope |
| serLo | output | 1 | Sample fell below the lower envelope |

## Verification
The assertions watch the phase handshake on every cycle: the sample and readout phases never overlap, the serial pair holds while shifting is paused, a row gap lasts exactly one cycle, an idle sample phase stays in place, and no flag is raised during the first frame after reset. The arithmetic of the envelopes, the strict comparisons, the decay rate, the raster order of delivery and the treatment of shift 0 are shown only by the bench's frames. These are compared pixel by pixel against an independent model, with samples offered during readout to show they are ignored.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_LOAD   = 2'd1,
    ST_SHIFT  = 2'd2
  } atcState_t;

  typedef struct packed {
    logic accept;
    logic first;
    logic loadRow;
    logic shift;
  } atcCtl_t;
endpackage

// File: rtl/atc_ctrl.sv
module atc_ctrl
  import atc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int ROWW = $clog2(ROWS),
  localparam int COLW = $clog2(COLS),
  localparam int IDXW = ROWW + COLW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pixValid,
  input  logic            shiftEn,
  output atcCtl_t         ctl,
  output logic [IDXW-1:0] pixIdx,
  output logic [ROWW-1:0] rowIdx,
  output logic            pixReady,
  output logic            serValid
);
  atcState_t       state;
  logic [COLW-1:0] colIdx;
  logic            firstFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_SAMPLE;
      pixIdx     <= '0;
      rowIdx     <= '0;
      colIdx     <= '0;
      firstFrame <= 1'b1;
    end else begin
      case (state)
        ST_SAMPLE: if (pixValid) begin
          if (pixIdx == IDXW'(ROWS * COLS - 1)) begin
            pixIdx     <= '0;
            state      <= ST_LOAD;
            firstFrame <= 1'b0;
          end else begin
            pixIdx <= pixIdx + 1'b1;
          end
        end
        ST_LOAD: begin
          colIdx <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: if (shiftEn) begin
          if (colIdx == COLW'(COLS - 1)) begin
            colIdx <= '0;
            if (rowIdx == ROWW'(ROWS - 1)) begin
              rowIdx <= '0;
              state  <= ST_SAMPLE;
            end else begin
              rowIdx <= rowIdx + 1'b1;
              state  <= ST_LOAD;
            end
          end else begin
            colIdx <= colIdx + 1'b1;
          end
        end
        default: state <= ST_SAMPLE;
      endcase
    end
  end

  always_comb begin
    ctl.accept  = (state == ST_SAMPLE) && pixValid;
    ctl.first   = firstFrame;
    ctl.loadRow = (state == ST_LOAD);
    ctl.shift   = (state == ST_SHIFT) && shiftEn;
  end

  assign pixReady = (state == ST_SAMPLE);
  assign serValid = (state == ST_SHIFT);
endmodule

// File: rtl/atc_datapath.sv
module atc_datapath
  import atc_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIXW  = 8,
  parameter int DECAY = 2,
  localparam int ROWW = $clog2(ROWS),
  localparam int COLW = $clog2(COLS),
  localparam int IDXW = ROWW + COLW,
  localparam int NPIX = ROWS * COLS
) (
  input  logic            clk,
  input  atcCtl_t         ctl,
  input  logic [IDXW-1:0] pixIdx,
  input  logic [ROWW-1:0] rowIdx,
  input  logic [PIXW-1:0] pixData,
  input  logic [2:0]      smoothShift,
  output logic            serHi,
  output logic            serLo
);
  logic [PIXW-1:0] upMem   [NPIX];
  logic [PIXW-1:0] downMem [NPIX];
  logic [1:0]      flagMem [NPIX];
  logic [1:0]      shReg   [COLS];

  logic [PIXW-1:0]   upOld, downOld, upNew, downNew;
  logic              aboveUp, belowDown;
  logic [3:0]        kFast, kSlow;
  logic signed [PIXW:0] upDiff, downDiff, upStep, downStep, upSum, downSum;

  assign upOld     = upMem[pixIdx];
  assign downOld   = downMem[pixIdx];
  assign aboveUp   = pixData > upOld;
  assign belowDown = pixData < downOld;
  assign kFast     = (smoothShift == 3'd0) ? 4'd1 : {1'b0, smoothShift};
  assign kSlow     = kFast + 4'(DECAY);

  always_comb begin
    upDiff   = $signed({1'b0, pixData}) - $signed({1'b0, upOld});
    downDiff = $signed({1'b0, pixData}) - $signed({1'b0, downOld});
    upStep   = aboveUp   ? (upDiff >>> kFast)   : (upDiff >>> kSlow);
    downStep = belowDown ? (downDiff >>> kFast) : (downDiff >>> kSlow);
    upSum    = $signed({1'b0, upOld}) + upStep;
    downSum  = $signed({1'b0, downOld}) + downStep;
    upNew    = ctl.first ? pixData : upSum[PIXW-1:0];
    downNew  = ctl.first ? pixData : downSum[PIXW-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctl.accept) begin
      upMem[pixIdx]   <= upNew;
      downMem[pixIdx] <= downNew;
      flagMem[pixIdx] <= ctl.first ? 2'b00 : {aboveUp, belowDown};
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_stage
    logic [IDXW-1:0] rdAddr;
    assign rdAddr = {rowIdx, COLW'(c)};
    always_ff @(posedge clk) begin
      if (ctl.loadRow) begin
        shReg[c] <= flagMem[rdAddr];
      end else if (ctl.shift) begin
        if (c == COLS - 1) shReg[c] <= 2'b00;
        else               shReg[c] <= shReg[(c + 1) % COLS];
      end
    end
  end

  assign serHi = shReg[0][1];
  assign serLo = shReg[0][0];
endmodule

// File: rtl/atc_array.sv
module atc_array
  import atc_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIXW  = 8,
  parameter int DECAY = 2,
  localparam int ROWW = $clog2(ROWS),
  localparam int COLW = $clog2(COLS),
  localparam int IDXW = ROWW + COLW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      smoothShift,
  input  logic            pixValid,
  input  logic [PIXW-1:0] pixData,
  output logic            pixReady,
  input  logic            shiftEn,
  output logic            serValid,
  output logic            serHi,
  output logic            serLo
);
  atcCtl_t         ctl;
  logic [IDXW-1:0] pixIdx;
  logic [ROWW-1:0] rowIdx;

  atc_ctrl #(.ROWS(ROWS), .COLS(COLS)) ctrl_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .shiftEn(shiftEn),
    .ctl(ctl), .pixIdx(pixIdx), .rowIdx(rowIdx),
    .pixReady(pixReady), .serValid(serValid)
  );

  atc_datapath #(.ROWS(ROWS), .COLS(COLS), .PIXW(PIXW), .DECAY(DECAY)) dp_i (
    .clk(clk), .ctl(ctl), .pixIdx(pixIdx), .rowIdx(rowIdx),
    .pixData(pixData), .smoothShift(smoothShift),
    .serHi(serHi), .serLo(serLo)
  );
endmodule

// File: rtl/atc_array_checker.sv
module atc_array_checker (
  input logic clk,
  input logic rstN,
  input logic pixValid,
  input logic pixReady,
  input logic shiftEn,
  input logic serValid,
  input logic serHi,
  input logic serLo
);
  logic inFirst, wasRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFirst <= 1'b1;
      wasRead <= 1'b0;
    end else begin
      if (serValid) wasRead <= 1'b1;
      if (pixReady && wasRead) inFirst <= 1'b0;
    end
  end

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(pixReady && serValid)); // R6
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    serValid && !shiftEn |=> serValid && $stable(serHi) && $stable(serLo)); // R7
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    serValid && inFirst |-> !serHi && !serLo); // R2
  AST_ROW_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serValid) && !pixReady |=> serValid); // R10
  AST_IDLE_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    pixReady && !pixValid |=> pixReady && !serValid); // R8
endmodule

bind atc_array atc_array_checker chk_i (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixReady(pixReady),
  .shiftEn(shiftEn), .serValid(serValid), .serHi(serHi), .serLo(serLo)
);

// File: tb/atc_array_tb_top.sv
module atc_array_tb_top;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int NPIX = ROWS * COLS;
  localparam int DECAY = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] smoothShift = 3'd3;
  logic       pixValid = 1'b0;
  logic [7:0] pixData = 8'd0;
  logic       pixReady;
  logic       shiftEn = 1'b0;
  logic       serValid, serHi, serLo;

  int checks = 0;
  int errors = 0;
  int upM [NPIX];
  int dnM [NPIX];
  bit expH [NPIX];
  bit expL [NPIX];
  bit firstModel = 1'b1;

  always #2 clk = ~clk;

  atc_array dut_i (
    .clk(clk), .rstN(rstN), .smoothShift(smoothShift), .pixValid(pixValid),
    .pixData(pixData), .pixReady(pixReady), .shiftEn(shiftEn),
    .serValid(serValid), .serHi(serHi), .serLo(serLo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat(input int f, input int idx);
    int r = idx / COLS;
    int c = idx % COLS;
    int b = (r * 5 + c * 3) & 255;
    int v;
    case (f)
      0: v = b;
      1: v = (c < 16) ? ((b + 60 > 255) ? 255 : b + 60) :
             (c < 32) ? ((b < 60) ? 0 : b - 60) : b;
      2: v = b ^ 8'h5A;
      3: v = 255 - b;
      default: v = 128;
    endcase
    return v;
  endfunction

  // Independent model of R2..R5
  function automatic void model(input int idx, input int f, input int kIn);
    int k = (kIn == 0) ? 1 : kIn;
    if (firstModel) begin
      expH[idx] = 0; expL[idx] = 0; upM[idx] = f; dnM[idx] = f;
    end else begin
      expH[idx] = f > upM[idx];
      expL[idx] = f < dnM[idx];
      upM[idx] = upM[idx] + ((f - upM[idx]) >>> (expH[idx] ? k : k + DECAY));
      dnM[idx] = dnM[idx] + ((f - dnM[idx]) >>> (expL[idx] ? k : k + DECAY));
    end
  endfunction

  task automatic sendFrame(input int f, input int k, input bit gaps);
    smoothShift = 3'(k);
    for (int i = 0; i < NPIX; i++) begin
      if (gaps && (i % 5 == 4)) begin
        pixValid = 1'b0;
        @(negedge clk);
        if (i == 4) chk(pixReady == 1'b1, "R8 idle keeps ready", pixReady, 1);
      end
      pixValid = 1'b1;
      pixData  = 8'(pat(f, i));
      model(i, pat(f, i), k);
      @(negedge clk);
    end
    pixValid = 1'b0;
    firstModel = 1'b0;
    chk(pixReady == 1'b0, "R6 ready drops after last pixel", pixReady, 0);
    chk(serValid == 1'b0, "R6 load cycle before first row", serValid, 0);
    @(negedge clk);
  endtask

  task automatic readFrame(input string tag, input bit junk);
    for (int r = 0; r < ROWS; r++) begin
      chk(serValid == 1'b1, "R6 row presented", serValid, 1);
      for (int c = 0; c < COLS; c++) begin
        int idx = r * COLS + c;
        logic h0, l0;
        pixValid = junk && !(r == ROWS - 1 && c == COLS - 1);
        pixData  = 8'hFF;
        chk(serHi == expH[idx], {tag, " R3 serHi"}, serHi, expH[idx]);
        chk(serLo == expL[idx], {tag, " R3 serLo"}, serLo, expL[idx]);
        if (idx % 97 == 5) begin
          h0 = serHi; l0 = serLo;
          @(negedge clk); @(negedge clk);
          chk(serValid && serHi == h0 && serLo == l0, "R7 hold without shiftEn",
              {serValid, serHi, serLo}, {1'b1, h0, l0});
        end
        shiftEn = 1'b1;
        @(negedge clk);
        shiftEn = 1'b0;
      end
      if (r < ROWS - 1) begin
        chk(serValid == 1'b0 && pixReady == 1'b0, "R10 one-cycle row gap",
            {serValid, pixReady}, 0);
        @(negedge clk);
      end else begin
        chk(pixReady == 1'b1 && serValid == 1'b0, "R9 back to sampling",
            {pixReady, serValid}, 2);
      end
    end
    pixValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pixReady == 1'b1, "R1 reset ready", pixReady, 1);
    chk(serValid == 1'b0, "R1 reset no output", serValid, 0);
    // R2: first frame all quiet, envelopes seeded
    sendFrame(0, 3, 1'b0);
    readFrame("R2 first frame", 1'b0);
    // R3 R4: bright and dark regions, with input gaps
    sendFrame(1, 3, 1'b1);
    readFrame("R4 frame1", 1'b0);
    // R5: shift 0 acts as 1; R8: samples offered during readout
    sendFrame(2, 0, 1'b0);
    readFrame("R5 frame2", 1'b1);
    // R8 is confirmed by this frame's flags matching the untouched model
    sendFrame(3, 7, 1'b0);
    readFrame("R8 frame3", 1'b0);
    sendFrame(4, 1, 1'b0);
    readFrame("R4 frame4", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule